// File: doc/BRIEF.md
# Pixel-Phase Edge Generator

This block produces the fast horizontal timing for a CCD sensor inside one pixel period. A phase counter, clocked from a fast master clock, splits every pixel period into 48 discrete edge positions. From that counter the block derives a reset-gate pulse and a horizontal clock, each with its own programmable rising and falling position, a second horizontal clock that is always the complement of the first, and two single-position sample strobes, one for the reset level and one for the data level.

Each location input is a 6-bit code made of a quadrant selector and an offset inside that quadrant. A divide-by-two mode lets the master clock run at twice the pixel rate. Each driven output has a 3-bit drive setting whose zero value turns the output's enable off, so a pad can float it. All location and drive inputs are copied into shadow registers only when the phase counter wraps. A change made partway through a pixel period therefore cannot cut a pulse short.

Top module: `pix_edge_gen`

## Requirements
- R1: With `div2_en` low, `phase_o` advances by one on every clock, counts 0 to 47, and steps from 47 back to 0, so one pixel period lasts 48 clocks.
- R2: With `div2_en` high, `phase_o` holds each value for exactly two clocks, so one pixel period lasts 96 clocks.
- R3: A location code is decoded as position = 12 × bits[5:4] + min(bits[3:0], 11). Bits[5:4] select one of the quadrants starting at 0, 12, 24 and 36. Offsets 12 to 15 act as 11.
- R4: `rg_out` goes high one clock after `phase_o` equals the decoded rise position and goes low one clock after it equals the decoded fall position. When rise is later than fall, the high window runs across position 0.
- R5: `h1_out` follows the same rule as R4 using `h1_rise_loc` and `h1_fall_loc`.
- R6: `h2_out` is always the logical inverse of `h1_out`.
- R7: When the decoded rise and fall positions of an output are equal, that output stays low for the whole pixel period.
- R8: `ref_smp` and `dat_smp` are high for exactly one phase position. Each strobe is high one clock after `phase_o` equals its decoded location, and low otherwise.
- R9: A drive setting of 0 drives the matching enable (`rg_oe`, `h1_oe`, `h2_oe`) low. Settings 1 to 7 drive it high.
- R10: Location and drive inputs are captured only at the clock edge where `phase_o` steps from 47 to 0. Changes made at other times have no effect on any output until that edge. Enables change only in the cycle where `phase_o` becomes 0.
- R11: While `rst_n` is low: `phase_o` is 0; `rg_out`, `h1_out` and both strobes are low; `h2_out` is high; all enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div2_en | input | 1 | Advance the phase only on every second clock |
| rg_rise_loc | input | 6 | Reset-gate rising location code |
| rg_fall_loc | input | 6 | Reset-gate falling location code |
| h1_rise_loc | input | 6 | Horizontal clock rising location code |
| h1_fall_loc | input | 6 | Horizontal clock falling location code |
| ref_smp_loc | input | 6 | Reset-level sample strobe location code |
| dat_smp_loc | input | 6 | Data-level sample strobe location code |
| rg_drv | input | 3 | Reset-gate drive setting, 0 floats the output |
| h1_drv | input | 3 | H1 drive setting, 0 floats the output |
| h2_drv | input | 3 | H2 drive setting, 0 floats the output |
| rg_out | output | 1 | Reset-gate level |
| rg_oe | output | 1 | Reset-gate output enable |
| h1_out | output | 1 | Horizontal clock level |
| h1_oe | output | 1 | H1 output enable |
| h2_out | output | 1 | Complement of the horizontal clock |
| h2_oe | output | 1 | H2 output enable |
| ref_smp | output | 1 | Reset-level sample strobe |
| dat_smp | output | 1 | Data-level sample strobe |
| phase_o | output | 6 | Current phase position within the pixel period |

## Verification
Every failure mode becomes visible at the ports within one pixel period.

- A corrupted phase counter shows on `phase_o` at the next clock: a skipped value, a missed wrap at 47, or a wrong hold length in divide-by-two mode.
- A wrong decoded position or a bad edge register moves a transition of `rg_out`, `h1_out` or a strobe. Checking every position of a settled period exposes it within 48 (or 96) clocks.
- A shadow register that loads at the wrong moment shows up in one of two ways. Either an enable changes in a cycle where `phase_o` is not 0, or an edge moves before the pixel period in which the new setting was applied has ended.

// File: rtl/pix_edge_pkg.sv
package pix_edge_pkg;

    localparam int PIX_POS_DEF   = 48;
    localparam int PIX_QUAD_DEF  = 4;
    localparam int PIX_LOC_W_DEF = 6;
    localparam int PIX_DRV_W_DEF = 3;

    // Location slots; each level channel owns a rise/fall pair in this order
    typedef enum int {
        LOC_RG_RISE = 0,
        LOC_RG_FALL = 1,
        LOC_H1_RISE = 2,
        LOC_H1_FALL = 3,
        LOC_SMP_REF = 4,
        LOC_SMP_DAT = 5,
        LOC_COUNT   = 6
    } loc_idx_e;

    typedef enum int {
        DRV_RG    = 0,
        DRV_H1    = 1,
        DRV_H2    = 2,
        DRV_COUNT = 3
    } drv_idx_e;

    localparam int N_LEVEL_CH  = 2;
    localparam int N_STROBE_CH = 2;

endpackage

// File: rtl/pix_phase_cnt.sv
module pix_phase_cnt #(
    parameter int N_POS = pix_edge_pkg::PIX_POS_DEF,
    parameter int PH_W  = $clog2(N_POS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            div2_en,
    output logic [PH_W-1:0] phase_o,
    output logic            wrap_o
);

    localparam logic [PH_W-1:0] LAST_POS = PH_W'(N_POS - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            half;
    } cnt_s;

    cnt_s cnt_d, cnt_q;
    logic tick;

    always_comb begin
        cnt_d     = cnt_q;
        tick      = !div2_en || cnt_q.half;
        cnt_d.half = div2_en ? !cnt_q.half : 1'b0;
        wrap_o    = tick && (cnt_q.phase == LAST_POS);
        if (tick) begin
            if (cnt_q.phase == LAST_POS) begin
                cnt_d.phase = '0;
            end else begin
                cnt_d.phase = cnt_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign phase_o = cnt_q.phase;

endmodule

// File: rtl/pix_loc_decode.sv
module pix_loc_decode #(
    parameter int LOC_W  = pix_edge_pkg::PIX_LOC_W_DEF,
    parameter int N_QUAD = pix_edge_pkg::PIX_QUAD_DEF,
    parameter int QSPAN  = 12,
    parameter int PH_W   = 6
) (
    input  logic [LOC_W-1:0] loc_i,
    output logic [PH_W-1:0]  pos_o
);

    localparam int QSEL_W = $clog2(N_QUAD);
    localparam int OFF_W  = LOC_W - QSEL_W;

    logic [QSEL_W-1:0] quad;
    logic [OFF_W-1:0]  offset;
    int                off_lim;

    always_comb begin
        quad    = loc_i[LOC_W-1 -: QSEL_W];
        offset  = loc_i[OFF_W-1:0];
        off_lim = (int'(offset) > QSPAN - 1) ? (QSPAN - 1) : int'(offset);
        pos_o   = PH_W'(int'(quad) * QSPAN + off_lim);
    end

endmodule

// File: rtl/pix_level_gen.sv
module pix_level_gen #(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase_i,
    input  logic [PH_W-1:0] rise_i,
    input  logic [PH_W-1:0] fall_i,
    output logic            level_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (rise_i == fall_i) begin
            lvl_d = 1'b0;
        end else if (phase_i == rise_i) begin
            lvl_d = 1'b1;
        end else if (phase_i == fall_i) begin
            lvl_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign level_o = lvl_q;

endmodule

// File: rtl/pix_strobe_gen.sv
module pix_strobe_gen #(
    parameter int PH_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase_i,
    input  logic [PH_W-1:0] pos_i,
    output logic            strobe_o
);

    logic stb_d, stb_q;

    always_comb begin
        stb_d = (phase_i == pos_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign strobe_o = stb_q;

endmodule

// File: rtl/pix_edge_gen.sv
module pix_edge_gen
    import pix_edge_pkg::*;
#(
    parameter int N_POS  = PIX_POS_DEF,
    parameter int N_QUAD = PIX_QUAD_DEF,
    parameter int LOC_W  = PIX_LOC_W_DEF,
    parameter int DRV_W  = PIX_DRV_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     div2_en,
    input  logic [LOC_W-1:0]         rg_rise_loc,
    input  logic [LOC_W-1:0]         rg_fall_loc,
    input  logic [LOC_W-1:0]         h1_rise_loc,
    input  logic [LOC_W-1:0]         h1_fall_loc,
    input  logic [LOC_W-1:0]         ref_smp_loc,
    input  logic [LOC_W-1:0]         dat_smp_loc,
    input  logic [DRV_W-1:0]         rg_drv,
    input  logic [DRV_W-1:0]         h1_drv,
    input  logic [DRV_W-1:0]         h2_drv,
    output logic                     rg_out,
    output logic                     rg_oe,
    output logic                     h1_out,
    output logic                     h1_oe,
    output logic                     h2_out,
    output logic                     h2_oe,
    output logic                     ref_smp,
    output logic                     dat_smp,
    output logic [$clog2(N_POS)-1:0] phase_o
);

    localparam int PH_W  = $clog2(N_POS);
    localparam int QSPAN = N_POS / N_QUAD;
    localparam int N_LOC = int'(LOC_COUNT);
    localparam int N_DRV = int'(DRV_COUNT);

    typedef struct packed {
        logic [N_LOC-1:0][LOC_W-1:0] loc;
        logic [N_DRV-1:0][DRV_W-1:0] drv;
    } shadow_s;

    shadow_s                live;
    shadow_s                shd_d, shd_q;
    logic                   wrap;
    logic [PH_W-1:0]        phase;
    logic [PH_W-1:0]        pos   [N_LOC];
    logic [N_LEVEL_CH-1:0]  level;
    logic [N_STROBE_CH-1:0] strobe;
    logic [N_DRV-1:0]       oe;

    // Phase counter
    pix_phase_cnt #(
        .N_POS (N_POS),
        .PH_W  (PH_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .div2_en (div2_en),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    // Gather live settings and update the shadow copy at the period boundary
    always_comb begin
        live                   = '0;
        live.loc[LOC_RG_RISE]  = rg_rise_loc;
        live.loc[LOC_RG_FALL]  = rg_fall_loc;
        live.loc[LOC_H1_RISE]  = h1_rise_loc;
        live.loc[LOC_H1_FALL]  = h1_fall_loc;
        live.loc[LOC_SMP_REF]  = ref_smp_loc;
        live.loc[LOC_SMP_DAT]  = dat_smp_loc;
        live.drv[DRV_RG]       = rg_drv;
        live.drv[DRV_H1]       = h1_drv;
        live.drv[DRV_H2]       = h2_drv;
        shd_d = wrap ? live : shd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '0;
        end else begin
            shd_q <= shd_d;
        end
    end

    // Location decode, one per slot
    for (genvar g = 0; g < N_LOC; g++) begin : g_dec
        pix_loc_decode #(
            .LOC_W  (LOC_W),
            .N_QUAD (N_QUAD),
            .QSPAN  (QSPAN),
            .PH_W   (PH_W)
        ) u_dec (
            .loc_i (shd_q.loc[g]),
            .pos_o (pos[g])
        );
    end

    // Level channels: rise slot 2*g, fall slot 2*g+1
    for (genvar g = 0; g < N_LEVEL_CH; g++) begin : g_lvl
        pix_level_gen #(
            .PH_W (PH_W)
        ) u_lvl (
            .clk     (clk),
            .rst_n   (rst_n),
            .phase_i (phase),
            .rise_i  (pos[2*g]),
            .fall_i  (pos[2*g+1]),
            .level_o (level[g])
        );
    end

    // Single-position strobes
    for (genvar g = 0; g < N_STROBE_CH; g++) begin : g_stb
        pix_strobe_gen #(
            .PH_W (PH_W)
        ) u_stb (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase_i  (phase),
            .pos_i    (pos[int'(LOC_SMP_REF) + g]),
            .strobe_o (strobe[g])
        );
    end

    // Output enables from shadowed drive settings
    for (genvar g = 0; g < N_DRV; g++) begin : g_oe
        assign oe[g] = |shd_q.drv[g];
    end

    assign rg_out  = level[0];
    assign h1_out  = level[1];
    assign h2_out  = ~level[1];
    assign ref_smp = strobe[0];
    assign dat_smp = strobe[1];
    assign rg_oe   = oe[DRV_RG];
    assign h1_oe   = oe[DRV_H1];
    assign h2_oe   = oe[DRV_H2];
    assign phase_o = phase;

endmodule

// File: rtl/pix_edge_gen_chk.sv
module pix_edge_gen_chk #(
    parameter int N_POS = 48,
    parameter int PH_W  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            div2_en,
    input logic [PH_W-1:0] phase_o,
    input logic            rg_oe,
    input logic            h1_oe,
    input logic            h2_oe
);

    localparam logic [PH_W-1:0] LAST_POS = PH_W'(N_POS - 1);

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o <= LAST_POS);

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> ((phase_o == $past(phase_o) + PH_W'(1)) ||
                               ($past(phase_o) == LAST_POS && phase_o == '0)));

    // R1
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div2_en |=> !$stable(phase_o));

    // R2
    half_rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div2_en && $past(div2_en) && !$stable(phase_o)) |=> $stable(phase_o));

    // R10
    oe_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rg_oe, h1_oe, h2_oe}) |-> (phase_o == '0));

endmodule

bind pix_edge_gen pix_edge_gen_chk #(.N_POS(N_POS), .PH_W(PH_W)) u_chk (.*);

// File: tb/sim_pix_edge_gen.sv
module sim_pix_edge_gen;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div2_en = 1'b0;
    logic [5:0] rg_rise_loc = '0, rg_fall_loc = '0, h1_rise_loc = '0;
    logic [5:0] h1_fall_loc = '0, ref_smp_loc = '0, dat_smp_loc = '0;
    logic [2:0] rg_drv = '0, h1_drv = '0, h2_drv = '0;
    logic       rg_out, rg_oe, h1_out, h1_oe, h2_out, h2_oe, ref_smp, dat_smp;
    logic [5:0] phase_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_edge_gen u0 (
        .clk(clk), .rst_n(rst_n), .div2_en(div2_en),
        .rg_rise_loc(rg_rise_loc), .rg_fall_loc(rg_fall_loc),
        .h1_rise_loc(h1_rise_loc), .h1_fall_loc(h1_fall_loc),
        .ref_smp_loc(ref_smp_loc), .dat_smp_loc(dat_smp_loc),
        .rg_drv(rg_drv), .h1_drv(h1_drv), .h2_drv(h2_drv),
        .rg_out(rg_out), .rg_oe(rg_oe), .h1_out(h1_out), .h1_oe(h1_oe),
        .h2_out(h2_out), .h2_oe(h2_oe), .ref_smp(ref_smp), .dat_smp(dat_smp),
        .phase_o(phase_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Expected settings (decoded positions and drive values)
    int e_rr, e_rf, e_hr, e_hf, e_sr, e_sd, e_drg, e_dh1, e_dh2;

    function automatic logic [5:0] enc(int q, int off);
        logic [1:0] qq;
        logic [3:0] oo;
        qq = q[1:0];
        oo = off[3:0];
        return {qq, oo};
    endfunction

    function automatic int pos_of(logic [5:0] loc);
        int off;
        off = int'(loc[3:0]);
        if (off > 11) off = 11;
        return int'(loc[5:4]) * 12 + off;
    endfunction

    function automatic int in_win(int p, int r, int f);
        if (r == f) return 0;
        if (r < f) return (p >= r && p < f) ? 1 : 0;
        return (p >= r || p < f) ? 1 : 0;
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_cfg(logic [5:0] rr, logic [5:0] rf, logic [5:0] hr,
                             logic [5:0] hf, logic [5:0] sr, logic [5:0] sd,
                             logic [2:0] dr, logic [2:0] d1, logic [2:0] d2);
        rg_rise_loc = rr; rg_fall_loc = rf;
        h1_rise_loc = hr; h1_fall_loc = hf;
        ref_smp_loc = sr; dat_smp_loc = sd;
        rg_drv = dr; h1_drv = d1; h2_drv = d2;
    endtask

    task automatic adopt_cfg();
        e_rr = pos_of(rg_rise_loc); e_rf = pos_of(rg_fall_loc);
        e_hr = pos_of(h1_rise_loc); e_hf = pos_of(h1_fall_loc);
        e_sr = pos_of(ref_smp_loc); e_sd = pos_of(dat_smp_loc);
        e_drg = int'(rg_drv); e_dh1 = int'(h1_drv); e_dh2 = int'(h2_drv);
    endtask

    task automatic check_one(int prev, string scen, bit chk_oe);
        check_eq({scen, " R4 rg_out"}, int'(rg_out), in_win(prev, e_rr, e_rf));
        check_eq({scen, " R5 h1_out"}, int'(h1_out), in_win(prev, e_hr, e_hf));
        check_eq({scen, " R6 h2_out"}, int'(h2_out), int'(!h1_out));
        check_eq({scen, " R8 ref_smp"}, int'(ref_smp), (prev == e_sr) ? 1 : 0);
        check_eq({scen, " R8 dat_smp"}, int'(dat_smp), (prev == e_sd) ? 1 : 0);
        if (chk_oe) begin
            check_eq({scen, " R9 rg_oe"}, int'(rg_oe), (e_drg != 0) ? 1 : 0);
            check_eq({scen, " R9 h1_oe"}, int'(h1_oe), (e_dh1 != 0) ? 1 : 0);
            check_eq({scen, " R9 h2_oe"}, int'(h2_oe), (e_dh2 != 0) ? 1 : 0);
        end
    endtask

    // Step to the first sample of a new pixel period
    task automatic wait_wrap();
        int  prev;
        bit  seen;
        prev = int'(phase_o);
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            seen = (phase_o == 6'd0) && (prev != 0);
            prev = int'(phase_o);
        end
    endtask

    task automatic check_samples(int n, string scen);
        int prev;
        prev = int'(phase_o);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_one(prev, scen, 1'b1);
            prev = int'(phase_o);
        end
    endtask

    task automatic settle_check(int n, string scen);
        wait_wrap();
        wait_wrap();
        check_samples(n, scen);
    endtask

    // Clocks from one period start to the next, and count of held samples
    task automatic measure_period(output int len, output int holds);
        int prev;
        wait_wrap();
        len = 0;
        holds = 0;
        prev = int'(phase_o);
        do begin
            @(negedge clk);
            len++;
            if (int'(phase_o) == prev) holds++;
            prev = int'(phase_o);
        end while (!(phase_o == 6'd0 && holds >= 0 && len > 1 && prev == 0 &&
                     !(len > 1 && phase_o != 6'd0)) || (div2_en && holds < 47));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_eq("R11 phase", int'(phase_o), 0);
        check_eq("R11 rg_out", int'(rg_out), 0);
        check_eq("R11 h1_out", int'(h1_out), 0);
        check_eq("R11 h2_out", int'(h2_out), 1);
        check_eq("R11 ref_smp", int'(ref_smp), 0);
        check_eq("R11 dat_smp", int'(dat_smp), 0);
        check_eq("R11 oe", int'({rg_oe, h1_oe, h2_oe}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_count();
        int prev;
        int len;
        wait_wrap();
        prev = int'(phase_o);
        len = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            check_eq("R1 step", int'(phase_o), (prev + 1) % 48);
            prev = int'(phase_o);
        end
        wait_wrap();
        do begin
            @(negedge clk);
            len++;
        end while (phase_o != 6'd0);
        check_eq("R1 period length", len, 48);
    endtask

    task automatic t_basic();
        drive_cfg(enc(0, 2), enc(1, 3), enc(0, 0), enc(2, 0),
                  enc(2, 5), enc(3, 7), 3'd5, 3'd5, 3'd1);
        adopt_cfg();
        settle_check(48, "basic");
    endtask

    task automatic t_wrap_window();
        drive_cfg(enc(3, 4), enc(0, 5), enc(3, 8), enc(0, 2),
                  enc(3, 11), enc(0, 0), 3'd7, 3'd1, 3'd2);
        adopt_cfg();
        settle_check(48, "wrapwin");
    endtask

    task automatic t_clamp_equal();
        int hi_cnt;
        // rg: 0x1E and 0x1B both decode to 23; h1: 0x0F -> 11, 0x2C -> 35
        drive_cfg(6'h1E, 6'h1B, 6'h0F, 6'h2C, 6'h3F, 6'h1C, 3'd4, 3'd4, 3'd4);
        adopt_cfg();
        check_eq("R3 clamp q1 off14", e_rr, 23);
        check_eq("R3 clamp q3 off15", e_sr, 47);
        settle_check(48, "R3 R7 clamp");
        hi_cnt = 0;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            hi_cnt += int'(h1_out);
            check_eq("R7 rg_out equal locations", int'(rg_out), 0);
        end
        check_eq("R3 h1 high width", hi_cnt, 24);
    endtask

    task automatic t_drive();
        drive_cfg(enc(0, 2), enc(1, 3), enc(0, 0), enc(2, 0),
                  enc(2, 5), enc(3, 7), 3'd0, 3'd7, 3'd3);
        adopt_cfg();
        settle_check(48, "R9 drv0");
        drive_cfg(enc(0, 2), enc(1, 3), enc(0, 0), enc(2, 0),
                  enc(2, 5), enc(3, 7), 3'd1, 3'd0, 3'd0);
        adopt_cfg();
        settle_check(48, "R9 drv1");
    endtask

    task automatic t_shadow();
        int prev;
        bit fin;
        drive_cfg(enc(0, 3), enc(1, 6), enc(0, 1), enc(2, 1),
                  enc(1, 0), enc(3, 0), 3'd5, 3'd5, 3'd5);
        adopt_cfg();
        settle_check(48, "R10 pre");
        while (phase_o != 6'd10) @(negedge clk);
        drive_cfg(enc(2, 2), enc(3, 3), enc(1, 4), enc(2, 9),
                  enc(0, 6), enc(2, 11), 3'd0, 3'd0, 3'd0);
        prev = int'(phase_o);
        fin = 1'b0;
        while (!fin) begin
            @(negedge clk);
            if (phase_o == 6'd0) begin
                check_one(prev, "R10 old at wrap", 1'b0);
                check_eq("R10 enables new at phase 0", int'({rg_oe, h1_oe, h2_oe}), 0);
                fin = 1'b1;
            end else begin
                check_one(prev, "R10 old mid-period", 1'b1);
            end
            prev = int'(phase_o);
        end
        adopt_cfg();
        settle_check(48, "R10 new");
    endtask

    task automatic t_div2();
        int prev;
        int len;
        int holds;
        drive_cfg(enc(0, 2), enc(1, 3), enc(0, 0), enc(2, 0),
                  enc(2, 5), enc(3, 7), 3'd5, 3'd5, 3'd1);
        adopt_cfg();
        div2_en = 1'b1;
        settle_check(96, "R2 div2");
        wait_wrap();
        len = 0;
        holds = 0;
        prev = int'(phase_o);
        for (int i = 0; i < 96; i++) begin
            @(negedge clk);
            len++;
            if (int'(phase_o) == prev) holds++;
            prev = int'(phase_o);
        end
        check_eq("R2 held samples per period", holds, 48);
        check_eq("R2 back at phase 0 after 96", int'(phase_o), 0);
        div2_en = 1'b0;
        check_eq("R2 period samples", len, 96);
    endtask

    initial begin
        t_reset();
        t_count();
        t_basic();
        t_wrap_window();
        t_clamp_equal();
        t_drive();
        t_shadow();
        t_div2();
        t_basic();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule